// File: doc/BRIEF.md
# Sticky Interrupt Status Aggregator with Two-Level Gating

This block gathers the event pulses of a serial-flash controller (four FIFO events from the transmit and receive queues and three events from the descriptor-driven DMA engine) into one sticky status word. Two threshold comparators watch the transmit and receive FIFO fill levels and feed two more status bits. Software reads the status, writes ones to clear the bits it has handled, and silences sources by rewriting the enable mask. An interrupt line is raised only where a status bit, its enable bit and its signal-enable bit are all set. The signal-enable mask is the last gate before the line.

A small sequencer runs a soft reset. From the running state `ST_RUN`, a pulse on `srst_i` moves it to `ST_CLEAR`. In `ST_CLEAR` every register returns to its reset value. The next cycle is `ST_ANNOUNCE`, which records the "both FIFOs empty" events. The sequencer then goes back to `ST_RUN`. The transitions are RUN→CLEAR on a request, CLEAR→ANNOUNCE always, and ANNOUNCE→RUN always. Register writes and incoming events have no effect outside `ST_RUN`.

Register addresses on `wr_addr_i` and `rd_addr_i` are: 0 status (write one to clear), 1 enable mask, 2 signal-enable mask, 3 thresholds.

Top module: `evt_irq_hub`

## Requirements
- R1: After the hardware reset, the status, enable and signal-enable registers read 0, the threshold register reads 0x0101 (both thresholds 1), and `irq_o` and `srst_busy_o` are low.
- R2: An event pulse sets its status bit at the next clock edge, even while that bit is masked. The status bit positions are: `fifo_evt_i[0]` TX empty → bit 0, `fifo_evt_i[1]` TX full → bit 1, `fifo_evt_i[2]` RX empty → bit 3, `fifo_evt_i[3]` RX full → bit 4, `dma_evt_i[0]` descriptor done → bit 9, `dma_evt_i[1]` packet complete → bit 10, `dma_evt_i[2]` DMA error → bit 11.
- R3: A status bit stays set until software writes a 1 to that bit at address 0. Status bits written with 0 are unchanged. Changing the masks does not clear status.
- R4: When an event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R5: Status bit 2 (TX threshold) is set in each cycle in which the TX level is at or below the TX threshold, which is held in bits 12:8 of address 3.
- R6: Status bit 5 (RX threshold) is set in each cycle in which the RX level is at or above the RX threshold, which is held in bits 4:0 of address 3.
- R7: `irq_o` is the OR over (status AND enable AND signal-enable), delayed by one register stage. Clearing either mask bit or the status bit drops the line one cycle after the register changes.
- R8: The unused bits 6 to 8 and 12 and up of the status, enable and signal-enable registers read 0, and writes to them are discarded.
- R9: A soft-reset pulse holds `srst_busy_o` high for two cycles. In the CLEAR cycle all registers go to their reset values and writes are discarded. In the ANNOUNCE cycle the status becomes exactly 0x009. After that the block runs again with both masks at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srst_i | input | 1 | Soft-reset request pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | DATA_W | Read data, combinational from the registers |
| fifo_evt_i | input | 4 | FIFO event pulses {RX full, RX empty, TX full, TX empty} |
| dma_evt_i | input | 3 | Descriptor event pulses {DMA error, packet complete, descriptor done} |
| tx_level_i | input | THR_W | TX FIFO fill level |
| rx_level_i | input | THR_W | RX FIFO fill level |
| srst_busy_o | output | 1 | High while the soft-reset sequence runs |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The assertions assume that every input is synchronous to `clk` and settles between edges. They also assume that `srst_i` is a one-cycle pulse issued while the block is running, and that FIFO levels never exceed the threshold field's range. The stimulus changes every input on the falling edge and never requests a soft reset while one is in progress. Outside the threshold tests it holds the TX level at its maximum and the RX level at zero, so the comparators stay quiet unless a test means to trigger them.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int STAT_W = 12;

    localparam int B_TXE = 0;
    localparam int B_TXF = 1;
    localparam int B_TXT = 2;
    localparam int B_RXE = 3;
    localparam int B_RXF = 4;
    localparam int B_RXT = 5;
    localparam int B_BDD = 9;
    localparam int B_PKT = 10;
    localparam int B_ERR = 11;

    localparam logic [STAT_W-1:0] STAT_MASK     = 12'hE3F;
    localparam logic [STAT_W-1:0] ANNOUNCE_MASK = 12'h009;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_CLEAR    = 2'd1,
        ST_ANNOUNCE = 2'd2
    } srst_state_e;

    typedef enum logic [1:0] {
        A_STATUS = 2'd0,
        A_ENABLE = 2'd1,
        A_SIGEN  = 2'd2,
        A_THRESH = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/evt_irq_srst_fsm.sv
module evt_irq_srst_fsm
    import evt_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic srst_i,
    output logic clr_all_o,
    output logic announce_o,
    output logic run_o
);

    srst_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:      if (srst_i) state_d = ST_CLEAR;
            ST_CLEAR:    state_d = ST_ANNOUNCE;
            ST_ANNOUNCE: state_d = ST_RUN;
            default:     state_d = ST_RUN;
        endcase
    end

    always_comb begin
        clr_all_o  = 1'b0;
        announce_o = 1'b0;
        run_o      = 1'b0;
        unique case (state_q)
            ST_RUN:      run_o      = 1'b1;
            ST_CLEAR:    clr_all_o  = 1'b1;
            ST_ANNOUNCE: announce_o = 1'b1;
            default:     run_o      = 1'b1;
        endcase
    end

    // R9
    clear_then_announce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAR) |=> (state_q == ST_ANNOUNCE));

    // R9
    announce_then_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ANNOUNCE) |=> (state_q == ST_RUN));

endmodule

// File: rtl/evt_irq_thr_cmp.sv
module evt_irq_thr_cmp #(
    parameter int W           = 5,
    parameter bit AT_OR_ABOVE = 1'b0
) (
    input  logic [W-1:0] level_i,
    input  logic [W-1:0] thr_i,
    output logic         hit_o
);

    generate
        if (AT_OR_ABOVE) begin : g_ge
            assign hit_o = (level_i >= thr_i);
        end else begin : g_le
            assign hit_o = (level_i <= thr_i);
        end
    endgenerate

endmodule

// File: rtl/evt_irq_stat_bank.sv
module evt_irq_stat_bank
    import evt_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_i,
    input  logic [STAT_W-1:0] w1c_i,
    input  logic              clr_all_i,
    input  logic              announce_i,
    output logic [STAT_W-1:0] stat_o
);

    logic [STAT_W-1:0] stat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          stat_q <= '0;
        else if (clr_all_i)  stat_q <= '0;
        else if (announce_i) stat_q <= ANNOUNCE_MASK;
        else                 stat_q <= ((stat_q & ~w1c_i) | set_i) & STAT_MASK;
    end

    assign stat_o = stat_q;

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_all_i && !announce_i) |=>
        ((stat_q & $past(stat_q & ~w1c_i)) == $past(stat_q & ~w1c_i)));

    // R4
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_all_i && !announce_i) |=>
        ((stat_q & $past(set_i & STAT_MASK)) == $past(set_i & STAT_MASK)));

    // R9
    announce_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        announce_i |=> (stat_q == ANNOUNCE_MASK));

endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
    import evt_irq_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int THR_W      = 5,
    parameter int TX_THR_RST = 1,
    parameter int RX_THR_RST = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [1:0]        rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic [3:0]        fifo_evt_i,
    input  logic [2:0]        dma_evt_i,
    input  logic [THR_W-1:0]  tx_level_i,
    input  logic [THR_W-1:0]  rx_level_i,
    output logic              srst_busy_o,
    output logic              irq_o
);

    localparam int TX_LSB = 8;
    localparam int RX_LSB = 0;
    localparam logic [THR_W-1:0] TX_RST_V = THR_W'(TX_THR_RST);
    localparam logic [THR_W-1:0] RX_RST_V = THR_W'(RX_THR_RST);

    logic              run, clr_all, announce;
    logic              wr_ok, tx_hit, rx_hit;
    logic [STAT_W-1:0] stat, set_vec, w1c_vec, wr_mask;
    logic [STAT_W-1:0] en_q, sig_q;
    logic [THR_W-1:0]  tx_thr_q, rx_thr_q;
    logic              irq_q;

    evt_irq_srst_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .srst_i     (srst_i),
        .clr_all_o  (clr_all),
        .announce_o (announce),
        .run_o      (run)
    );

    evt_irq_thr_cmp #(.W(THR_W), .AT_OR_ABOVE(1'b0)) u_tx_cmp (
        .level_i (tx_level_i),
        .thr_i   (tx_thr_q),
        .hit_o   (tx_hit)
    );

    evt_irq_thr_cmp #(.W(THR_W), .AT_OR_ABOVE(1'b1)) u_rx_cmp (
        .level_i (rx_level_i),
        .thr_i   (rx_thr_q),
        .hit_o   (rx_hit)
    );

    assign wr_ok   = wr_en_i && run;
    assign wr_mask = wr_data_i[STAT_W-1:0] & STAT_MASK;
    assign w1c_vec = (wr_ok && wr_addr_i == A_STATUS) ? wr_mask : '0;

    always_comb begin
        set_vec        = '0;
        set_vec[B_TXE] = fifo_evt_i[0];
        set_vec[B_TXF] = fifo_evt_i[1];
        set_vec[B_RXE] = fifo_evt_i[2];
        set_vec[B_RXF] = fifo_evt_i[3];
        set_vec[B_TXT] = tx_hit;
        set_vec[B_RXT] = rx_hit;
        set_vec[B_BDD] = dma_evt_i[0];
        set_vec[B_PKT] = dma_evt_i[1];
        set_vec[B_ERR] = dma_evt_i[2];
    end

    evt_irq_stat_bank u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_vec),
        .w1c_i      (w1c_vec),
        .clr_all_i  (clr_all),
        .announce_i (announce),
        .stat_o     (stat)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= '0;
            sig_q    <= '0;
            tx_thr_q <= TX_RST_V;
            rx_thr_q <= RX_RST_V;
        end else if (clr_all) begin
            en_q     <= '0;
            sig_q    <= '0;
            tx_thr_q <= TX_RST_V;
            rx_thr_q <= RX_RST_V;
        end else if (wr_ok) begin
            unique case (reg_addr_e'(wr_addr_i))
                A_ENABLE: en_q  <= wr_mask;
                A_SIGEN:  sig_q <= wr_mask;
                A_THRESH: begin
                    tx_thr_q <= wr_data_i[TX_LSB +: THR_W];
                    rx_thr_q <= wr_data_i[RX_LSB +: THR_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(stat & en_q & sig_q);
    end

    always_comb begin
        rd_data_o = '0;
        unique case (reg_addr_e'(rd_addr_i))
            A_STATUS: rd_data_o[STAT_W-1:0] = stat;
            A_ENABLE: rd_data_o[STAT_W-1:0] = en_q;
            A_SIGEN:  rd_data_o[STAT_W-1:0] = sig_q;
            A_THRESH: begin
                rd_data_o[TX_LSB +: THR_W] = tx_thr_q;
                rd_data_o[RX_LSB +: THR_W] = rx_thr_q;
            end
            default: ;
        endcase
    end

    assign irq_o       = irq_q;
    assign srst_busy_o = !run;

    // R7
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_q & sig_q) == '0) |=> !irq_o);

    // R7
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat & en_q & sig_q)) |=> irq_o);

    // R5
    tx_thr_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tx_level_i <= tx_thr_q) |=> stat[B_TXT]);

    // R6
    rx_thr_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && rx_level_i >= rx_thr_q) |=> stat[B_RXT]);

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat | en_q | sig_q) & ~STAT_MASK) == '0);

endmodule

// File: tb/evt_irq_hub_bench.sv
module evt_irq_hub_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        srst_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_addr_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [1:0]  rd_addr_i = '0;
    logic [31:0] rd_data_o;
    logic [3:0]  fifo_evt_i = '0;
    logic [2:0]  dma_evt_i = '0;
    logic [4:0]  tx_level_i = 5'd31;
    logic [4:0]  rx_level_i = 5'd0;
    logic        srst_busy_o;
    logic        irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    evt_irq_hub u_evt_irq_hub (
        .clk         (clk),
        .rst_n       (rst_n),
        .srst_i      (srst_i),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .rd_addr_i   (rd_addr_i),
        .rd_data_o   (rd_data_o),
        .fifo_evt_i  (fifo_evt_i),
        .dma_evt_i   (dma_evt_i),
        .tx_level_i  (tx_level_i),
        .rx_level_i  (rx_level_i),
        .srst_busy_o (srst_busy_o),
        .irq_o       (irq_o)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
            summary();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr_i = a;
        #1;
        d = rd_data_o;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        @(negedge clk);
        rd(2'd0, d); check("R1 status", d, 32'h0);
        rd(2'd1, d); check("R1 enable", d, 32'h0);
        rd(2'd2, d); check("R1 sigen", d, 32'h0);
        rd(2'd3, d); check("R1 thresh", d, 32'h0101);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        check("R1 busy", {31'b0, srst_busy_o}, 32'h0);
    endtask

    task automatic t_event_map();
        logic [31:0] d;
        int fbit[4] = '{0, 1, 3, 4};
        int dbit[3] = '{9, 10, 11};
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); fifo_evt_i = 4'(1 << i);
            @(negedge clk); fifo_evt_i = '0;
            rd(2'd0, d); check("R2 fifo event map", d, 32'(1) << fbit[i]);
            check("R2 masked no irq", {31'b0, irq_o}, 32'h0);
            wr(2'd0, 32'hFFF);
        end
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); dma_evt_i = 3'(1 << i);
            @(negedge clk); dma_evt_i = '0;
            rd(2'd0, d); check("R2 dma event map", d, 32'(1) << dbit[i]);
            wr(2'd0, 32'hFFF);
        end
        rd(2'd0, d); check("R3 cleared all", d, 32'h0);
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        @(negedge clk); dma_evt_i = 3'b001;
        @(negedge clk); dma_evt_i = '0;
        idle(5);
        rd(2'd0, d); check("R3 sticky hold", d, 32'h200);
        wr(2'd0, 32'h001);
        rd(2'd0, d); check("R3 other bit w1c no effect", d, 32'h200);
        wr(2'd0, 32'h200);
        rd(2'd0, d); check("R3 w1c clears", d, 32'h0);
    endtask

    task automatic t_clear_race();
        logic [31:0] d;
        @(negedge clk); dma_evt_i = 3'b010;
        @(negedge clk); dma_evt_i = 3'b010;
        wr_en_i = 1'b1; wr_addr_i = 2'd0; wr_data_i = 32'h400;
        @(negedge clk); dma_evt_i = '0; wr_en_i = 1'b0;
        rd(2'd0, d); check("R4 event beats clear", d, 32'h400);
        wr(2'd0, 32'h400);
        rd(2'd0, d); check("R4 later clear works", d, 32'h0);
    endtask

    task automatic t_tx_thr();
        logic [31:0] d;
        wr(2'd3, 32'h0A1F);
        rd(2'd3, d); check("R5 thresh readback", d, 32'h0A1F);
        tx_level_i = 5'd11;
        wr(2'd0, 32'hFFF);
        rd(2'd0, d); check("R5 above tx thr quiet", d, 32'h0);
        tx_level_i = 5'd10;
        @(negedge clk);
        rd(2'd0, d); check("R5 at tx thr fires", d, 32'h004);
        tx_level_i = 5'd31;
        wr(2'd0, 32'hFFF);
        rd(2'd0, d); check("R5 after clear", d, 32'h0);
    endtask

    task automatic t_rx_thr();
        logic [31:0] d;
        rx_level_i = 5'd30;
        @(negedge clk);
        rd(2'd0, d); check("R6 below rx thr quiet", d, 32'h0);
        rx_level_i = 5'd31;
        @(negedge clk);
        rd(2'd0, d); check("R6 at rx thr fires", d, 32'h020);
        rx_level_i = 5'd0;
        wr(2'd0, 32'hFFF);
        wr(2'd3, 32'h0101);
        rd(2'd0, d); check("R6 after clear", d, 32'h0);
    endtask

    task automatic t_irq_gate();
        logic [31:0] d;
        @(negedge clk); dma_evt_i = 3'b100;
        @(negedge clk); dma_evt_i = '0;
        wr(2'd1, 32'h800);
        @(negedge clk);
        check("R7 sigen gate closed", {31'b0, irq_o}, 32'h0);
        wr(2'd2, 32'h800);
        check("R7 one cycle delay", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        check("R7 irq raised", {31'b0, irq_o}, 32'h1);
        wr(2'd1, 32'h0);
        @(negedge clk);
        check("R7 enable masks irq", {31'b0, irq_o}, 32'h0);
        rd(2'd0, d); check("R3 mask keeps status", d, 32'h800);
        wr(2'd1, 32'h800);
        @(negedge clk);
        check("R7 irq again", {31'b0, irq_o}, 32'h1);
        wr(2'd0, 32'h800);
        @(negedge clk);
        check("R7 w1c drops irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, d); check("R8 enable reserved", d, 32'hE3F);
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, d); check("R8 sigen reserved", d, 32'hE3F);
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d); check("R8 status reserved", d, 32'h0);
    endtask

    task automatic t_soft_reset();
        logic [31:0] d;
        wr(2'd3, 32'h0405);
        @(negedge clk); dma_evt_i = 3'b001;
        @(negedge clk); dma_evt_i = '0;
        @(negedge clk);
        check("R9 irq before srst", {31'b0, irq_o}, 32'h1);
        srst_i = 1'b1;
        @(negedge clk); srst_i = 1'b0;
        check("R9 busy in clear", {31'b0, srst_busy_o}, 32'h1);
        wr_en_i = 1'b1; wr_addr_i = 2'd1; wr_data_i = 32'h001;
        @(negedge clk); wr_en_i = 1'b0;
        check("R9 busy in announce", {31'b0, srst_busy_o}, 32'h1);
        @(negedge clk);
        check("R9 busy released", {31'b0, srst_busy_o}, 32'h0);
        rd(2'd0, d); check("R9 status announce", d, 32'h009);
        rd(2'd1, d); check("R9 enable cleared, write ignored", d, 32'h0);
        rd(2'd2, d); check("R9 sigen cleared", d, 32'h0);
        rd(2'd3, d); check("R9 thresh restored", d, 32'h0101);
        @(negedge clk);
        check("R9 irq low after srst", {31'b0, irq_o}, 32'h0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_event_map();
        t_sticky();
        t_clear_race();
        t_tx_thr();
        t_rx_thr();
        t_irq_gate();
        t_reserved();
        t_soft_reset();
        idle(2);
        summary();
    end

endmodule